// File: doc/BRIEF.md
# Programmable CRC Generator with Input FIFO

This block computes a cyclic redundancy checksum over words written by a host. The host programs a polynomial of order 1 to 32, an initial register value, a data word length (8, 16 or 32 bits) and the order in which the bits of each word enter the checksum. The order and the word length are set on their own, so any combination is allowed. Words are queued in a FIFO whose capacity follows the word length. Each queued word is moved into a shift buffer. A serial Galois-style LFSR then consumes that buffer two bits per clock.

All host access goes through one write port with a 3-bit select. Select 0 pushes a data word. Select 1 writes the polynomial mask. Select 2 writes the initial value. Select 3 writes the configuration. Select 4 clears flags. The checksum is always visible on `result`. One sticky interrupt output can be raised either when the FIFO runs empty or when the engine has shifted all pending data. Configuration should be changed only while the engine is idle.

Top module: `crc_forge`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), these values hold: `result` is 0, `irq` is 0, `overflow` is 0, `fifo_empty` is 1 and `fifo_full` is 0. The configuration resets to order 32, 32-bit words, MSB-first, FIFO-empty interrupt source, and run off. The polynomial resets to 0.
- R2: The polynomial mask is written at select 1. For order N, each data bit d updates the register in two steps. First, fb = reg[N-1] XOR d. Then reg = ((reg << 1) XOR (fb ? poly : 0)) masked to its low N bits. `result` is always the register masked to its low N bits.
- R3: The configuration is written at select 3 with these fields:
  - bits [4:0]: order minus 1
  - bits [6:5]: width code
  - bit 7: LSB-first when 1, MSB-first when 0
  - bit 8: interrupt source
  - bit 9: run

  Only the low W bits of a pushed word take part in the checksum. MSB-first feeds bit W-1 first. LSB-first feeds bit 0 first.
- R4: The width code sets both the word length and the FIFO capacity. Code 0 gives 8 bits and 16 entries. Code 1 gives 16 bits and 8 entries. Codes 2 and 3 give 32 bits and 4 entries. `fifo_full` is 1 while the entry count has reached the capacity.
- R5: A data write (select 0) while `fifo_full` is 1 is dropped and sets the sticky `overflow`. Writing select 4 with bit 1 set clears `overflow`.
- R6: A word is taken from the FIFO only on an edge where run is 1, the engine is idle and the FIFO is not empty. The engine then shifts two bits per clock for W/2 clocks. With interrupt source 1, the edge that sets run on a single queued 32-bit word is followed by `irq` high after 18 edges, counting that edge.
- R7: An initial-value write (select 2) loads the full register only while the engine is idle. Written while bits are still being shifted, it has no effect.
- R8: With interrupt source 0, `irq` is set when a pop leaves the FIFO empty. A data write accepted on that same edge suppresses the event. With source 1, `irq` is set when the final two bits of a word are shifted while the FIFO holds no entries.
- R9: `irq` is sticky. Writing select 4 with bit 0 set clears it. If a set event falls on the same edge as the clear, `irq` stays 1.
- R10: With run at 0, no entries leave the FIFO and `result` does not change. Any word already in the shift buffer completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the shift engine handles two bits per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 3 | Target: 0 data, 1 polynomial, 2 initial value, 3 configuration, 4 flag clear |
| wr_data | input | 32 | Write value |
| result | output | 32 | Checksum register masked to the programmed order |
| irq | output | 1 | Sticky interrupt flag |
| fifo_full | output | 1 | FIFO holds as many entries as the current width allows |
| fifo_empty | output | 1 | FIFO holds no entries |
| overflow | output | 1 | Sticky flag for a dropped data write |

## Verification
Two pairs of events can fall on the same edge, and both are provoked on purpose. In the first, a data push lands on the edge that pops the last queued word. The interrupt must then stay low until the second word drains. In the second, a flag-clear write lands on the exact edge where the final bit pair shifts out. The set must win and the flag must read 1 afterwards. Both outcomes are judged twice: by directed checks, and by a cycle-by-cycle behavioural model that tracks queue contents and per-bit shifting and is compared with every output on every clock.

// File: rtl/crc_forge_pkg.sv
`timescale 1ns/1ps
package crc_forge_pkg;

   localparam int unsigned DATA_W = 32;

   typedef enum logic [1:0] {
      WID_8   = 2'd0,
      WID_16  = 2'd1,
      WID_32  = 2'd2,
      WID_32X = 2'd3
   } wid_e;

   typedef enum logic [2:0] {
      SEL_DATA = 3'd0,
      SEL_POLY = 3'd1,
      SEL_SEED = 3'd2,
      SEL_CFG  = 3'd3,
      SEL_CLR  = 3'd4
   } sel_e;

   // Bit 9 down to bit 0 of a configuration write.
   typedef struct packed {
      logic       run;
      logic       irq_on_done;
      logic       lsb_first;
      wid_e       wid;
      logic [4:0] order_m1;
   } cfg_t;

   function automatic int unsigned wid_bits(wid_e w);
      case (w)
         WID_8:   return 8;
         WID_16:  return 16;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/crc_fifo.sv
`timescale 1ns/1ps
module crc_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   input  logic [CNT_W-1:0] cap,
   output logic [W-1:0]     pop_data,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty,
   output logic             empty_evt,
   output logic             drop
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;
   logic             push_ok, pop_ok;

   assign full      = (count >= cap);
   assign empty     = (count == '0);
   assign push_ok   = push && !full;
   assign pop_ok    = pop && !empty;
   assign drop      = push && full;
   assign empty_evt = pop_ok && (count == CNT_W'(1)) && !push_ok;
   assign pop_data  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

endmodule

// File: rtl/crc_engine.sv
`timescale 1ns/1ps
module crc_engine import crc_forge_pkg::*; #(
   parameter int unsigned W     = 32,
   parameter int unsigned STEPS = 2,
   localparam int unsigned ORD_W = $clog2(W),
   localparam int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ORD_W-1:0] order_m1,
   input  logic [W-1:0]     poly,
   input  wid_e             wid,
   input  logic             lsb_first,
   input  logic             seed_we,
   input  logic [W-1:0]     seed,
   input  logic             load,
   input  logic [W-1:0]     load_data,
   output logic [W-1:0]     crc_out,
   output logic             idle,
   output logic             last
);

   logic [W-1:0]     crc, sbuf, mask, crc_nxt, sbuf_nxt;
   logic [CNT_W-1:0] left, nbits;

   assign mask    = {W{1'b1}} >> (ORD_W'(W - 1) - order_m1);
   assign crc_out = crc & mask;
   assign idle    = (left == '0);
   assign last    = (left == CNT_W'(STEPS));
   assign nbits   = CNT_W'(wid_bits(wid));

   // STEPS serial LFSR steps unrolled into one clock.
   always_comb begin
      logic [W-1:0] c, b;
      logic         din, fb;
      c = crc;
      b = sbuf;
      for (int k = 0; k < STEPS; k++) begin
         din = lsb_first ? b[0] : b[W-1];
         fb  = din ^ c[order_m1];
         c   = ((c << 1) ^ (fb ? poly : '0)) & mask;
         b   = lsb_first ? (b >> 1) : (b << 1);
      end
      crc_nxt  = c;
      sbuf_nxt = b;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc  <= '0;
         sbuf <= '0;
         left <= '0;
      end else if (!idle) begin
         crc  <= crc_nxt;
         sbuf <= sbuf_nxt;
         left <= left - CNT_W'(STEPS);
      end else begin
         if (seed_we) crc <= seed;
         if (load) begin
            sbuf <= lsb_first ? load_data : (load_data << (W - wid_bits(wid)));
            left <= nbits;
         end
      end
   end

endmodule

// File: rtl/crc_sticky.sv
`timescale 1ns/1ps
module crc_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set | (q & ~clr);
   end

endmodule

// File: rtl/crc_forge.sv
`timescale 1ns/1ps
module crc_forge import crc_forge_pkg::*; #(
   parameter int unsigned FIFO_BITS = 128,
   parameter int unsigned STEPS     = 2,
   localparam int unsigned DEPTH    = FIFO_BITS / 8,
   localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] result,
   output logic              irq,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic              overflow
);

   if (FIFO_BITS < 32 || (FIFO_BITS & (FIFO_BITS - 1)) != 0) begin : g_bad_fifo
      $error("crc_forge: FIFO_BITS must be a power of two of at least 32");
   end
   if (STEPS == 0 || (8 % STEPS) != 0) begin : g_bad_steps
      $error("crc_forge: STEPS must divide 8");
   end

   cfg_t              cfg;
   logic [DATA_W-1:0] poly;
   logic [CNT_W-1:0]  cap, fifo_count;
   logic [DATA_W-1:0] fifo_head;
   logic              hit_data, hit_seed, hit_clr;
   logic              fifo_pop, eng_idle, eng_last;
   logic              empty_evt, drop_evt, done_evt, irq_set;
   logic              cfg_run, cfg_irq_sel;

   assign hit_data    = wr_en && (wr_sel == SEL_DATA);
   assign hit_seed    = wr_en && (wr_sel == SEL_SEED);
   assign hit_clr     = wr_en && (wr_sel == SEL_CLR);
   assign cfg_run     = cfg.run;
   assign cfg_irq_sel = cfg.irq_on_done;

   always_comb begin
      case (cfg.wid)
         WID_8:   cap = CNT_W'(DEPTH);
         WID_16:  cap = CNT_W'(DEPTH / 2);
         default: cap = CNT_W'(DEPTH / 4);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg  <= '{run: 1'b0, irq_on_done: 1'b0, lsb_first: 1'b0, wid: WID_32, order_m1: 5'd31};
         poly <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_CFG)  cfg  <= cfg_t'(wr_data[9:0]);
         if (wr_sel == SEL_POLY) poly <= wr_data;
      end
   end

   assign fifo_pop = cfg.run && eng_idle && !fifo_empty;
   assign done_evt = eng_last && fifo_empty;
   assign irq_set  = cfg.irq_on_done ? done_evt : empty_evt;

   crc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (hit_data),
      .push_data (wr_data),
      .pop       (fifo_pop),
      .cap       (cap),
      .pop_data  (fifo_head),
      .count     (fifo_count),
      .full      (fifo_full),
      .empty     (fifo_empty),
      .empty_evt (empty_evt),
      .drop      (drop_evt)
   );

   crc_engine #(.W(DATA_W), .STEPS(STEPS)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .order_m1  (cfg.order_m1),
      .poly      (poly),
      .wid       (cfg.wid),
      .lsb_first (cfg.lsb_first),
      .seed_we   (hit_seed),
      .seed      (wr_data),
      .load      (fifo_pop),
      .load_data (fifo_head),
      .crc_out   (result),
      .idle      (eng_idle),
      .last      (eng_last)
   );

   crc_sticky u_irq_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (irq_set),
      .clr   (hit_clr && wr_data[0]),
      .q     (irq)
   );

   crc_sticky u_ovf_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (drop_evt),
      .clr   (hit_clr && wr_data[1]),
      .q     (overflow)
   );

endmodule

// File: rtl/crc_forge_chk.sv
`timescale 1ns/1ps
module crc_forge_chk #(
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [2:0]       wr_sel,
   input logic [31:0]      wr_data,
   input logic [31:0]      result,
   input logic             irq,
   input logic             fifo_full,
   input logic             fifo_empty,
   input logic             overflow,
   input logic             fifo_pop,
   input logic             eng_idle,
   input logic             cfg_run,
   input logic             cfg_irq_sel,
   input logic [CNT_W-1:0] fifo_count
);

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq && !overflow && fifo_empty && !fifo_full && result == 32'd0));

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_idle && !(wr_en && (wr_sel == 3'd2 || wr_sel == 3'd3))) |=> $stable(result));

   a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !fifo_pop && !(wr_en && wr_sel == 3'd3)) |=> fifo_full);

   a_r5_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd0 && fifo_full) |=> overflow);

   a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !(wr_en && wr_sel == 3'd4 && wr_data[1])) |=> overflow);

   a_r6_pop_starts_shift: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !eng_idle);

   a_r8_empty_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_irq_sel && fifo_pop && fifo_count == CNT_W'(1) && !(wr_en && wr_sel == 3'd0)) |=> irq);

   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_en && wr_sel == 3'd4 && wr_data[0])) |=> irq);

   a_r10_no_pop_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_run |-> !fifo_pop);

endmodule

bind crc_forge crc_forge_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .result      (result),
   .irq         (irq),
   .fifo_full   (fifo_full),
   .fifo_empty  (fifo_empty),
   .overflow    (overflow),
   .fifo_pop    (fifo_pop),
   .eng_idle    (eng_idle),
   .cfg_run     (cfg_run),
   .cfg_irq_sel (cfg_irq_sel),
   .fifo_count  (fifo_count)
);

// File: tb/tb_crc_forge.sv
`timescale 1ns/1ps
module tb_crc_forge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = 3'd0;
   logic [31:0] wr_data = 32'd0;
   logic [31:0] result;
   logic        irq, fifo_full, fifo_empty, overflow;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   crc_forge dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .result(result), .irq(irq), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
      .overflow(overflow)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0]  m_crc, m_poly;
   int           m_om1, m_wid;
   bit           m_lsb, m_isel, m_run, m_irq, m_ov;
   logic [31:0]  fq[$];
   bit           bq[$];

   function automatic int bits_of(int w);
      return (w == 0) ? 8 : (w == 1) ? 16 : 32;
   endfunction

   function automatic int cap_of(int w);
      return (w == 0) ? 16 : (w == 1) ? 8 : 4;
   endfunction

   function automatic logic [31:0] msk(int om1);
      return 32'hFFFF_FFFF >> (31 - om1);
   endfunction

   function automatic logic [31:0] ref_crc(logic [31:0] seed, logic [31:0] p, int om1,
                                           logic [31:0] d, int n, bit lsb);
      logic [31:0] c;
      c = seed;
      for (int i = 0; i < n; i++) begin
         bit b, f;
         b = lsb ? d[i] : d[n-1-i];
         f = b ^ c[om1];
         c = ((c << 1) ^ (f ? p : 32'd0)) & msk(om1);
      end
      return c;
   endfunction

   task automatic model_step();
      bit full, acc, pop, done_e, empty_e;
      logic [31:0] w;
      int n;
      if (!rst_n) begin
         m_crc = 0; m_poly = 0; m_om1 = 31; m_wid = 2; m_lsb = 0; m_isel = 0;
         m_run = 0; m_irq = 0; m_ov = 0;
         fq.delete(); bq.delete();
         return;
      end
      full    = fq.size() >= cap_of(m_wid);
      acc     = wr_en && wr_sel == 3'd0 && !full;
      pop     = m_run && bq.size() == 0 && fq.size() != 0;
      done_e  = bq.size() == 2 && fq.size() == 0;
      empty_e = pop && fq.size() == 1 && !acc;
      if (bq.size() != 0) begin
         for (int s = 0; s < 2; s++) begin
            bit b, f;
            b = bq.pop_front();
            f = b ^ m_crc[m_om1];
            m_crc = ((m_crc << 1) ^ (f ? m_poly : 32'd0)) & msk(m_om1);
         end
      end else if (wr_en && wr_sel == 3'd2) begin
         m_crc = wr_data;
      end
      if (pop) begin
         w = fq.pop_front();
         n = bits_of(m_wid);
         for (int i = 0; i < n; i++) bq.push_back(m_lsb ? w[i] : w[n-1-i]);
      end
      if (acc) fq.push_back(wr_data);
      m_irq = (m_isel ? done_e : empty_e) || (m_irq && !(wr_en && wr_sel == 3'd4 && wr_data[0]));
      m_ov  = (wr_en && wr_sel == 3'd0 && full) || (m_ov && !(wr_en && wr_sel == 3'd4 && wr_data[1]));
      if (wr_en && wr_sel == 3'd1) m_poly = wr_data;
      if (wr_en && wr_sel == 3'd3) begin
         m_om1 = int'(wr_data[4:0]); m_wid = int'(wr_data[6:5]); m_lsb = wr_data[7];
         m_isel = wr_data[8]; m_run = wr_data[9];
      end
   endtask

   task automatic cmp_field(string req, string name, logic [31:0] act, logic [31:0] exp);
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: got %h expected %h", req, name, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      model_step();
      #1;
      n_cmp++;
      cmp_field("R2", "result",   result, m_crc & msk(m_om1));
      cmp_field("R9", "irq",      32'(irq), 32'(m_irq));
      cmp_field("R5", "overflow", 32'(overflow), 32'(m_ov));
      cmp_field("R4", "full",     32'(fifo_full), 32'(fq.size() >= cap_of(m_wid)));
      cmp_field("R4", "empty",    32'(fifo_empty), 32'(fq.size() == 0));
   end

   // ---------------- directed stimulus ----------------
   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] sel, logic [31:0] d);
      wr_sel = sel; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(int om1, int wid, bit lsb, bit isel, bit run);
      wr(3'd3, {22'd0, run, isel, lsb, 2'(wid), 5'(om1)});
   endtask

   task automatic wait_idle();
      int g = 0;
      while ((fq.size() != 0 || bq.size() != 0) && g < 2000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic push_digits();
      for (int i = 1; i <= 9; i++) wr(3'd0, 32'h30 + i);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL R6 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r_lsb, exp_v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 result", result, 32'd0);
      check("R1 irq", 32'(irq), 32'd0);
      check("R1 overflow", 32'(overflow), 32'd0);
      check("R1 empty", 32'(fifo_empty), 32'd1);
      check("R1 full", 32'(fifo_full), 32'd0);

      // R2: 8-bit polynomial 0x07 over "123456789"
      cfg(7, 0, 0, 0, 0);
      wr(3'd1, 32'h07);
      wr(3'd2, 32'h0);
      push_digits();
      cfg(7, 0, 0, 0, 1);
      wait_idle();
      check("R2 crc8 check value", result, 32'hF4);
      check("R8 irq on fifo drained", 32'(irq), 32'd1);
      wr(3'd4, 32'h1);
      check("R9 irq cleared", 32'(irq), 32'd0);

      // R2: order 32, all-ones start, MSB-first
      cfg(31, 0, 0, 0, 0);
      wr(3'd1, 32'h04C1_1DB7);
      wr(3'd2, 32'hFFFF_FFFF);
      push_digits();
      cfg(31, 0, 0, 0, 1);
      wait_idle();
      check("R2 crc32 check value", result, 32'h0376_E6E7);

      // R3: LSB-first 0x01 (upper bits ignored) equals MSB-first 0x80
      cfg(15, 0, 1, 0, 0);
      wr(3'd1, 32'h1021);
      wr(3'd2, 32'h0);
      wr(3'd0, 32'hABCD_EF01);
      cfg(15, 0, 1, 0, 1);
      wait_idle();
      r_lsb = result;
      cfg(15, 0, 0, 0, 0);
      wr(3'd2, 32'h0);
      wr(3'd0, 32'h80);
      cfg(15, 0, 0, 0, 1);
      wait_idle();
      check("R3 bit order", result, r_lsb);
      check("R3 against reference", result, ref_crc(0, 32'h1021, 15, 32'h80, 8, 1'b0));

      // R4/R5: capacity per width, overflow
      cfg(31, 1, 0, 0, 0);
      for (int i = 0; i < 7; i++) wr(3'd0, 32'h100 + i);
      check("R4 16-bit not full at 7", 32'(fifo_full), 32'd0);
      wr(3'd0, 32'h1FF);
      check("R4 16-bit full at 8", 32'(fifo_full), 32'd1);
      wr(3'd0, 32'h2FF);
      check("R5 overflow set", 32'(overflow), 32'd1);
      wr(3'd4, 32'h2);
      check("R5 overflow cleared", 32'(overflow), 32'd0);
      cfg(31, 1, 0, 0, 1);
      wait_idle();
      cfg(31, 0, 0, 0, 0);
      for (int i = 0; i < 15; i++) wr(3'd0, 32'(i));
      check("R4 8-bit not full at 15", 32'(fifo_full), 32'd0);
      wr(3'd0, 32'h55);
      check("R4 8-bit full at 16", 32'(fifo_full), 32'd1);
      cfg(31, 0, 0, 0, 1);
      wait_idle();
      cfg(31, 2, 0, 0, 0);
      for (int i = 0; i < 3; i++) wr(3'd0, 32'h1234_0000 + i);
      check("R4 32-bit not full at 3", 32'(fifo_full), 32'd0);
      wr(3'd0, 32'hCAFE_F00D);
      check("R4 32-bit full at 4", 32'(fifo_full), 32'd1);

      // R10: stopped FIFO keeps its entries
      exp_v = result;
      repeat (10) @(negedge clk);
      check("R10 no drain while stopped", 32'(fifo_empty), 32'd0);
      check("R10 result frozen", result, exp_v);
      cfg(31, 2, 0, 0, 1);
      wait_idle();
      check("R10 drains once run", 32'(fifo_empty), 32'd1);

      // R6: latency with shift-complete source
      cfg(31, 2, 0, 1, 0);
      wr(3'd4, 32'h1);
      wr(3'd0, 32'h1234_5678);
      cfg(31, 2, 0, 1, 1);
      n = 1;
      while (!irq && n < 100) begin
         @(negedge clk);
         n++;
      end
      check("R6 edges to shift complete", 32'(n), 32'd18);
      wait_idle();

      // R9: clear on the same edge as the set
      cfg(31, 2, 0, 1, 0);
      wr(3'd4, 32'h1);
      wr(3'd0, 32'h0F0F_0F0F);
      cfg(31, 2, 0, 1, 1);
      repeat (16) @(negedge clk);
      wr(3'd4, 32'h1);
      check("R9 set wins over clear", 32'(irq), 32'd1);
      wr(3'd4, 32'h1);
      check("R9 clear alone", 32'(irq), 32'd0);

      // R8: push on the edge that pops the last entry
      cfg(31, 2, 0, 0, 1);
      wr(3'd4, 32'h1);
      wr(3'd0, 32'hAAAA_0001);
      wr(3'd0, 32'hAAAA_0002);
      check("R8 collided pop keeps irq low", 32'(irq), 32'd0);
      wait_idle();
      check("R8 irq after real drain", 32'(irq), 32'd1);

      // R7: initial value while idle vs busy
      wr(3'd2, 32'hDEAD_BEEF);
      check("R7 seed loads when idle", result, 32'hDEAD_BEEF);
      cfg(11, 2, 0, 0, 1);
      check("R2 order mask", result, 32'h0000_0EEF);
      cfg(31, 2, 0, 0, 1);
      wr(3'd1, 32'h04C1_1DB7);
      wr(3'd2, 32'h0);
      wr(3'd0, 32'h0000_00FF);
      repeat (3) @(negedge clk);
      wr(3'd2, 32'hFFFF_FFFF);
      wait_idle();
      check("R7 seed ignored while busy", result,
            ref_crc(32'h0, 32'h04C1_1DB7, 31, 32'h0000_00FF, 32, 1'b0));

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule